// File: doc/BRIEF.md
# Reverse Link Packetizer

This block turns a stream of recorded samples into packets on a single serial line. The line drives a load-modulation transmitter that uses the same coil as the forward command link. A packet starts with a 16-bit header taken from configuration. Then come a configurable number of sample words, and then a fixed 16-bit closing pattern. Each sample word is 11 bits: a stimulation-onset flag followed by a 10-bit ADC code.

After every packet the line stays quiet for a programmable number of bit periods. For that whole span the block raises a window output, which tells the forward receiver that it may take commands. Transmit and receive therefore share the coil by taking turns in time.

The bit period is a programmable number of clock cycles. For example, 8 cycles at 16 MHz gives 2 Mb/s, and 32 cycles gives 0.5 Mb/s. A 4:1 select chooses what drives the output wire. All configuration is captured once, at the start of each packet.

Top module: `rlp_packetizer`

## Requirements
- R1: While reset is high, `tx_bit`, `rx_window`, `underrun` and `smp_ready` are all 0. The first header bit is on the line in the first cycle after reset is released.
- R2: A packet is sent MSB first in this order: the 16-bit header, then the sample words, then the closing pattern 16'hC3A5. Software must keep the header different from 16'hC3A5.
- R3: A sample is taken on a cycle where `smp_ready` and `smp_valid` are both high. Its word is sent as `smp_stim` first, then `smp_code` from bit 9 down to bit 0.
- R4: Every bit, including every gap bit, holds for `cfg_bit_div`+1 clock cycles.
- R5: `rx_window` rises in the cycle after the last cycle of the closing pattern. It stays high for exactly `cfg_gap_len`×(`cfg_bit_div`+1) cycles, with the packet stream low. One low idle cycle follows, and then the next header starts.
- R6: `rx_window` is low throughout every packet. With a gap length of 0 it never rises, and the idle cycle comes straight after the closing pattern.
- R7: With a payload length of 0, the closing pattern follows the header directly and no sample is taken.
- R8: If a sample word is due while `smp_valid` is low, the line holds its last bit and `smp_ready` stays high. `underrun` then goes to 1 and stays 1 until reset. Sending resumes with the sample word once `smp_valid` rises.
- R9: Header, payload length, gap length, bit divider and source select are sampled in the idle cycle that starts a packet. Changes made at any other time wait for the next packet.
- R10: The source select sets what drives `tx_bit`: 0 sends the packet stream, 1 sends constant low, 2 sends constant high, and 3 sends the inverted packet stream. `rx_window` timing does not depend on the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_header | input | 16 | Header word for the next packet |
| cfg_payload_len | input | LEN_W (8) | Samples per packet |
| cfg_gap_len | input | GAP_W (12) | Quiet gap length in bit periods |
| cfg_bit_div | input | DIV_W (6) | Clock cycles per bit minus one |
| cfg_src_sel | input | 2 | Output source select |
| smp_valid | input | 1 | A sample is offered |
| smp_stim | input | 1 | Stimulation-onset flag of the offered sample |
| smp_code | input | 10 | ADC code of the offered sample |
| smp_ready | output | 1 | A sample word slot is due this cycle |
| tx_bit | output | 1 | Serial line to the modulator |
| rx_window | output | 1 | Forward command window open |
| underrun | output | 1 | Sticky flag: a sample was missing when due |

## Verification
The embedded properties are checked on every cycle:
- the bit timer never runs past the divider;
- a stall freezes the line;
- the underrun flag never clears outside reset;
- the window opens only straight after a closing pattern;
- captured configuration does not move inside a packet;
- an accepted sample always begins a fresh word.

Only the bench scenarios can show the rest. These are the exact bit order of header, sample words and closing pattern; the gap length counted in cycles; the behaviour with zero payload and zero gap; each source-select encoding; and the resumption after a stall.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    localparam int HDR_W   = 16;
    localparam int MARK_W  = 16;
    localparam int CODE_W  = 10;
    localparam int WORD_W  = CODE_W + 1;
    localparam int SH_W    = HDR_W;
    localparam int BC_W    = $clog2(SH_W);
    localparam logic [MARK_W-1:0] END_MARK = 16'hC3A5;

    typedef enum logic [2:0] {
        ST_START,
        ST_HDR,
        ST_PAY,
        ST_MRK,
        ST_GAP
    } rl_state_e;

    typedef enum logic [1:0] {
        SRC_PKT  = 2'd0,
        SRC_LOW  = 2'd1,
        SRC_HIGH = 2'd2,
        SRC_INV  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic              stim;
        logic [CODE_W-1:0] code;
    } smp_word_t;

    // left-aligns a sample word in the shift register so it leaves MSB first
    function automatic logic [SH_W-1:0] word_to_sh(smp_word_t w);
        return {w, {(SH_W-WORD_W){1'b0}}};
    endfunction

endpackage

// File: rtl/rlp_bit_timer.sv
module rlp_bit_timer #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic             at_end
);

    logic [DIV_W-1:0] cnt;

    assign at_end = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (at_end) begin
            if (adv) cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= div);  // R4

endmodule

// File: rtl/rlp_framer.sv
module rlp_framer
    import rlp_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int GAP_W = 12,
    parameter int DIV_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HDR_W-1:0]  cfg_header,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_sel,
    input  logic              smp_valid,
    input  logic              smp_stim,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              at_end,
    output logic              timer_clr,
    output logic              timer_adv,
    output logic [DIV_W-1:0]  div_q,
    output logic [1:0]        sel_q,
    output logic              smp_ready,
    output logic              pkt_bit,
    output logic              rx_window,
    output logic              underrun
);

    rl_state_e        state;
    logic [SH_W-1:0]  sh;
    logic [BC_W-1:0]  bit_cnt;
    logic [LEN_W-1:0] smp_cnt, len_q;
    logic [GAP_W-1:0] gap_cnt, gap_q;
    smp_word_t        in_word;
    logic             in_frame, word_last, need_smp, stall, step;

    always_comb begin
        in_word.stim = smp_stim;
        in_word.code = smp_code;
    end

    assign in_frame  = (state == ST_HDR) || (state == ST_PAY) || (state == ST_MRK);
    assign word_last = (bit_cnt == '0);
    assign need_smp  = in_frame && (state != ST_MRK) && word_last && (smp_cnt != len_q);
    assign smp_ready = at_end && need_smp;
    assign stall     = smp_ready && !smp_valid;
    assign step      = at_end && !stall;
    assign timer_adv = !stall;
    assign timer_clr = (state == ST_START);
    assign pkt_bit   = in_frame ? sh[SH_W-1] : 1'b0;
    assign rx_window = (state == ST_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_START;
            sh       <= '0;
            bit_cnt  <= '0;
            smp_cnt  <= '0;
            gap_cnt  <= '0;
            len_q    <= '0;
            gap_q    <= '0;
            div_q    <= '0;
            sel_q    <= '0;
            underrun <= 1'b0;
        end else begin
            if (stall) underrun <= 1'b1;
            unique case (state)
                ST_START: begin
                    len_q   <= cfg_len;
                    gap_q   <= cfg_gap;
                    div_q   <= cfg_div;
                    sel_q   <= cfg_sel;
                    sh      <= cfg_header;
                    bit_cnt <= BC_W'(HDR_W - 1);
                    smp_cnt <= '0;
                    state   <= ST_HDR;
                end
                ST_HDR, ST_PAY, ST_MRK: begin
                    if (step) begin
                        if (!word_last) begin
                            sh      <= sh << 1;
                            bit_cnt <= bit_cnt - 1'b1;
                        end else if (state == ST_MRK) begin
                            gap_cnt <= '0;
                            state   <= (gap_q == '0) ? ST_START : ST_GAP;
                        end else if (smp_cnt == len_q) begin
                            sh      <= END_MARK;
                            bit_cnt <= BC_W'(MARK_W - 1);
                            state   <= ST_MRK;
                        end else begin
                            sh      <= word_to_sh(in_word);
                            bit_cnt <= BC_W'(WORD_W - 1);
                            smp_cnt <= smp_cnt + 1'b1;
                            state   <= ST_PAY;
                        end
                    end
                end
                ST_GAP: begin
                    if (at_end) begin
                        if (gap_cnt == gap_q - 1'b1) state <= ST_START;
                        else                          gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_START;
            endcase
        end
    end

    AST_STALL_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
        (smp_ready && !smp_valid) |=> $stable(pkt_bit));  // R8
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);  // R8
    AST_WINDOW_AFTER_MARK: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_window) |-> $past(state) == ST_MRK);  // R5
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_START) |=> ($stable(len_q) && $stable(gap_q) && $stable(div_q) && $stable(sel_q)));  // R9
    AST_TAKE_STARTS_WORD: assert property (@(posedge clk) disable iff (rst)
        (smp_ready && smp_valid) |=> (state == ST_PAY && bit_cnt == BC_W'(WORD_W - 1)));  // R3

endmodule

// File: rtl/rlp_src_mux.sv
module rlp_src_mux
    import rlp_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       pkt_bit,
    output logic       tx_bit
);

    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_PKT:  tx_bit = pkt_bit;
            SRC_LOW:  tx_bit = 1'b0;
            SRC_HIGH: tx_bit = 1'b1;
            SRC_INV:  tx_bit = ~pkt_bit;
            default:  tx_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rlp_packetizer.sv
module rlp_packetizer
    import rlp_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int GAP_W = 12,
    parameter int DIV_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HDR_W-1:0]  cfg_header,
    input  logic [LEN_W-1:0]  cfg_payload_len,
    input  logic [GAP_W-1:0]  cfg_gap_len,
    input  logic [DIV_W-1:0]  cfg_bit_div,
    input  logic [1:0]        cfg_src_sel,
    input  logic              smp_valid,
    input  logic              smp_stim,
    input  logic [CODE_W-1:0] smp_code,
    output logic              smp_ready,
    output logic              tx_bit,
    output logic              rx_window,
    output logic              underrun
);

    logic             at_end, timer_clr, timer_adv, pkt_bit;
    logic [DIV_W-1:0] div_q;
    logic [1:0]       sel_q;

    rlp_bit_timer #(.DIV_W(DIV_W)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (timer_clr),
        .adv    (timer_adv),
        .div    (div_q),
        .at_end (at_end)
    );

    rlp_framer #(.LEN_W(LEN_W), .GAP_W(GAP_W), .DIV_W(DIV_W)) framer_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_header (cfg_header),
        .cfg_len    (cfg_payload_len),
        .cfg_gap    (cfg_gap_len),
        .cfg_div    (cfg_bit_div),
        .cfg_sel    (cfg_src_sel),
        .smp_valid  (smp_valid),
        .smp_stim   (smp_stim),
        .smp_code   (smp_code),
        .at_end     (at_end),
        .timer_clr  (timer_clr),
        .timer_adv  (timer_adv),
        .div_q      (div_q),
        .sel_q      (sel_q),
        .smp_ready  (smp_ready),
        .pkt_bit    (pkt_bit),
        .rx_window  (rx_window),
        .underrun   (underrun)
    );

    rlp_src_mux mux_i (
        .sel     (sel_q),
        .pkt_bit (pkt_bit),
        .tx_bit  (tx_bit)
    );

    AST_LOW_SOURCE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sel_q == 2'd1) |-> !tx_bit);  // R10

endmodule

// File: tb/rlp_packetizer_tb.sv
module rlp_packetizer_tb_top;

    localparam int LEN_W = 8;
    localparam int GAP_W = 12;
    localparam int DIV_W = 6;
    localparam int NPKT  = 12;
    localparam logic [15:0] MARK = 16'hC3A5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       cfg_header = '0;
    logic [LEN_W-1:0]  cfg_payload_len = '0;
    logic [GAP_W-1:0]  cfg_gap_len = '0;
    logic [DIV_W-1:0]  cfg_bit_div = '0;
    logic [1:0]        cfg_src_sel = '0;
    logic              smp_valid = 1'b1;
    logic              smp_stim = 1'b0;
    logic [9:0]        smp_code = '0;
    logic              smp_ready, tx_bit, rx_window, underrun;

    int total = 0;
    int fails = 0;

    logic        s_stim [0:255];
    logic [9:0]  s_code [0:255];
    int          drv_idx = 0;
    int          exp_idx = 0;

    logic [15:0] p_hdr [0:NPKT];
    int          p_len [0:NPKT];
    int          p_gap [0:NPKT];
    int          p_div [0:NPKT];
    int          p_sel [0:NPKT];

    always #10 clk = ~clk;

    rlp_packetizer #(.LEN_W(LEN_W), .GAP_W(GAP_W), .DIV_W(DIV_W)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_header      (cfg_header),
        .cfg_payload_len (cfg_payload_len),
        .cfg_gap_len     (cfg_gap_len),
        .cfg_bit_div     (cfg_bit_div),
        .cfg_src_sel     (cfg_src_sel),
        .smp_valid       (smp_valid),
        .smp_stim        (smp_stim),
        .smp_code        (smp_code),
        .smp_ready       (smp_ready),
        .tx_bit          (tx_bit),
        .rx_window       (rx_window),
        .underrun        (underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic map_src(input int sel, input logic b);
        case (sel)
            0: return b;
            1: return 1'b0;
            2: return 1'b1;
            default: return ~b;
        endcase
    endfunction

    task automatic apply_cfg(input int i);
        cfg_header      = p_hdr[i];
        cfg_payload_len = LEN_W'(p_len[i]);
        cfg_gap_len     = GAP_W'(p_gap[i]);
        cfg_bit_div     = DIV_W'(p_div[i]);
        cfg_src_sel     = 2'(p_sel[i]);
    endtask

    // sample driver: a word is taken at the posedge after a negedge showing ready&&valid
    initial begin
        bit took = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                drv_idx = 0;
                took = 1'b0;
            end else if (took) begin
                drv_idx = (drv_idx + 1) % 256;
            end
            smp_stim = s_stim[drv_idx];
            smp_code = s_code[drv_idx];
            took = smp_ready && smp_valid && !rst;
        end
    end

    // called at the first cycle of a header; returns at the first cycle of the next header
    task automatic run_packet(input int i);
        logic bits [0:127];
        int   n = 0;
        int   bad_bit = 0, bad_win = 0, gap_cyc = 0;
        int   act_b = 0, exp_b = 0;
        for (int k = 15; k >= 0; k--) begin bits[n] = p_hdr[i][k]; n++; end
        for (int s = 0; s < p_len[i]; s++) begin
            bits[n] = s_stim[exp_idx]; n++;
            for (int k = 9; k >= 0; k--) begin bits[n] = s_code[exp_idx][k]; n++; end
            exp_idx = (exp_idx + 1) % 256;
        end
        for (int k = 15; k >= 0; k--) begin bits[n] = MARK[k]; n++; end
        for (int b = 0; b < n; b++) begin
            for (int c = 0; c <= p_div[i]; c++) begin
                if (tx_bit !== map_src(p_sel[i], bits[b])) begin
                    if (bad_bit == 0) begin act_b = int'(tx_bit); exp_b = int'(map_src(p_sel[i], bits[b])); end
                    bad_bit++;
                end
                if (rx_window !== 1'b0) bad_win++;
                @(negedge clk);
            end
        end
        chk(bad_bit == 0, $sformatf("R2 R3 R4 R10 stream pkt %0d first bad bit", i), act_b, exp_b);
        chk(bad_win == 0, $sformatf("R6 window low in pkt %0d (bad cycles)", i), bad_win, 0);
        bad_bit = 0;
        while (rx_window === 1'b1 && gap_cyc < 100000) begin
            if (tx_bit !== map_src(p_sel[i], 1'b0)) bad_bit++;
            gap_cyc++;
            @(negedge clk);
        end
        chk(gap_cyc == p_gap[i] * (p_div[i] + 1), $sformatf("R5 gap cycles pkt %0d", i),
            gap_cyc, p_gap[i] * (p_div[i] + 1));
        chk(bad_bit == 0 && tx_bit === map_src(p_sel[i], 1'b0),
            $sformatf("R5 quiet line in gap/idle pkt %0d", i), bad_bit, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 256; k++) begin
            s_stim[k] = 1'($urandom);
            s_code[k] = 10'($urandom);
        end
        // directed corner cases, then random packets
        p_hdr[0] = 16'h1234; p_len[0] = 3; p_gap[0] = 5; p_div[0] = 0; p_sel[0] = 0;
        p_hdr[1] = 16'hBEEF; p_len[1] = 0; p_gap[1] = 2; p_div[1] = 3; p_sel[1] = 0;  // R7
        p_hdr[2] = 16'h00FF; p_len[2] = 2; p_gap[2] = 0; p_div[2] = 7; p_sel[2] = 0;  // R6 zero gap
        p_hdr[3] = 16'h5A5A; p_len[3] = 1; p_gap[3] = 3; p_div[3] = 1; p_sel[3] = 1;  // R10
        p_hdr[4] = 16'hA0A0; p_len[4] = 1; p_gap[4] = 2; p_div[4] = 1; p_sel[4] = 2;  // R10
        p_hdr[5] = 16'h0F0F; p_len[5] = 2; p_gap[5] = 4; p_div[5] = 2; p_sel[5] = 3;  // R10
        for (int i = 6; i <= NPKT; i++) begin
            logic [15:0] h;
            do h = 16'($urandom); while (h == MARK);
            p_hdr[i] = h;
            p_len[i] = $urandom_range(0, 6);
            p_gap[i] = $urandom_range(0, 9);
            p_div[i] = $urandom_range(0, 7);
            p_sel[i] = (i % 3 == 0) ? 3 : 0;
        end

        apply_cfg(0);
        smp_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_bit == 1'b0 && rx_window == 1'b0, "R1 reset line and window", int'(tx_bit) + 2 * int'(rx_window), 0);
        chk(underrun == 1'b0 && smp_ready == 1'b0, "R1 reset flag and ready", int'(underrun) + 2 * int'(smp_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        exp_idx = 0;
        for (int i = 0; i < NPKT; i++) begin
            apply_cfg(i + 1);  // R9: next config arrives mid-packet
            run_packet(i);
        end

        // R8 underrun scenario
        rst = 1'b1;
        smp_valid = 1'b0;
        p_hdr[0] = 16'h0001; p_len[0] = 2; p_gap[0] = 3; p_div[0] = 1; p_sel[0] = 0;
        apply_cfg(0);
        s_stim[0] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        repeat (10) @(negedge clk);
        chk(underrun == 1'b0, "R8 no underrun while header runs", int'(underrun), 0);
        repeat (40) @(negedge clk);
        chk(tx_bit == 1'b1, "R8 line held at last header bit", int'(tx_bit), 1);
        chk(underrun == 1'b1, "R8 underrun raised", int'(underrun), 1);
        chk(smp_ready == 1'b1, "R8 ready held during stall", int'(smp_ready), 1);
        smp_valid = 1'b1;
        @(negedge clk);
        chk(tx_bit == 1'b0, "R8 resume with stim flag of sample", int'(tx_bit), 0);
        repeat (5) @(negedge clk);
        chk(underrun == 1'b1, "R8 underrun sticky", int'(underrun), 1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(underrun == 1'b0, "R8 R1 underrun cleared by reset", int'(underrun), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule